// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt conditions of one UART channel and presents them as an 8-bit identification word. The word names only the most urgent pending source, and the block drives an active-high interrupt request beside it. Software reads the word to find out which service routine to run. Reading it while it names the transmit-empty source counts as servicing that source.

Seven sources are resolved across six urgency levels. Two of them, the flow-control stop-character detection and the handshake-line change, exist only while the enhanced-feature mode input is high. The stop-character indication is sticky: it is held until a resume character is seen, and a read of the word does not clear it. The FIFO-mode flag is mirrored into the two top bits of the word. The word is resolved combinationally and captured in a register on every clock, so software never reads a half-updated value.

Top module: `uart_intid`

## Requirements
- R1: After reset the word reads 0x01 and `irq_o` is 0.
- R2: Bit 0 of `stat_o` is 0 exactly when some enabled source is pending. `irq_o` is always the inverse of bit 0.
- R3: Bits 5..0 report the most urgent pending source with these codes, listed from most to least urgent: line-status error 000110, receive timeout 001100, receive ready 000100, transmit empty 000010, modem change 000000, stop-character 010000, handshake change 100000. With nothing pending they read 000001.
- R4: Receive timeout and receive ready share one urgency level. When both are pending, the timeout code is reported.
- R5: A source counts only while its bit in `src_en_i` is 1. The bit map is: 0 line status, 1 timeout, 2 ready, 3 transmit empty, 4 modem, 5 stop-character, 6 handshake.
- R6: While `enh_en_i` is 0, bits 5 and 4 read 0. The stop-character and handshake sources are then masked, and a stop-character pulse is not recorded.
- R7: A stop-character pulse in enhanced mode sets a sticky flag. The flag stays set, whatever is read, until a resume pulse arrives. A resume pulse in the same cycle as a stop pulse leaves the flag clear.
- R8: Bits 7:6 read 11 when `fifo_en_i` is 1 and 00 when it is 0.
- R9: A read strobe while the word shows transmit empty (low nibble 0010) clears that source. The source is armed again only by a new rising edge of `thr_empty_i`. A read while another code is shown leaves it armed.
- R10: The word reflects the inputs of the previous clock cycle. Every change appears one cycle after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_en_i | input | 7 | Per-source enables (bit map in R5) |
| lsr_err_i | input | 1 | Receive line-status error condition |
| rx_tmo_i | input | 1 | Receive data timeout condition |
| rx_rdy_i | input | 1 | Receive data ready condition |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| modem_chg_i | input | 1 | Modem status change condition |
| flow_chg_i | input | 1 | Handshake line change condition |
| xoff_det_i | input | 1 | Stop-character detected pulse |
| xon_det_i | input | 1 | Resume-character detected pulse |
| enh_en_i | input | 1 | Enhanced-feature mode enable |
| fifo_en_i | input | 1 | FIFO mode flag |
| rd_stat_i | input | 1 | Read strobe for the identification word |
| stat_o | output | 8 | Identification word |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench sets up collisions between adjacent urgency levels. The most telling is timeout against ready, where a design with the wrong order inside the level would report 000100 instead of 001100. The enhanced-mode masking is tested separately: a design without it would raise bits 4 and 5 while the mode is off. The bench checks that the stop-character flag outlives reads and clears only on a resume pulse; a flag that cleared on read would drop back to 0x01 too early. The transmit-empty source is read while both shown and hidden behind a line-status error. A design that cleared it on any read, or re-armed it from the level instead of the edge, would report the wrong code after the read.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned ID_W    = 5;

  // Source index equals urgency rank (0 = most urgent).
  typedef enum logic [2:0] {
    SRC_LSR  = 3'd0,
    SRC_TMO  = 3'd1,
    SRC_RDY  = 3'd2,
    SRC_THRE = 3'd3,
    SRC_MSR  = 3'd4,
    SRC_XOFF = 3'd5,
    SRC_FLOW = 3'd6
  } src_e;

  // Identification bits 5..1 for each source rank.
  function automatic logic [ID_W-1:0] src_code(input int unsigned idx);
    logic [ID_W-1:0] c;
    case (idx)
      0:       c = 5'b00011;
      1:       c = 5'b00110;
      2:       c = 5'b00010;
      3:       c = 5'b00001;
      4:       c = 5'b00000;
      5:       c = 5'b01000;
      6:       c = 5'b10000;
      default: c = 5'b00000;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/uart_intid_flags.sv
module uart_intid_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_empty_i,
  input  logic thre_clr_i,
  input  logic xoff_set_i,
  input  logic xon_i,
  output logic thre_arm_d_o,
  output logic xoff_d_o
);
  logic thr_empty_q;
  logic thre_arm_q;
  logic xoff_q;
  logic thre_rise;

  assign thre_rise = thr_empty_i & ~thr_empty_q;

  always_comb begin
    thre_arm_d_o = thre_arm_q;
    if (thre_clr_i) thre_arm_d_o = 1'b0;
    if (thre_rise)  thre_arm_d_o = 1'b1;
    if (!thr_empty_i) thre_arm_d_o = 1'b0;
  end

  always_comb begin
    xoff_d_o = xoff_q;
    if (xoff_set_i) xoff_d_o = 1'b1;
    if (xon_i)      xoff_d_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_empty_q <= 1'b0;
      thre_arm_q  <= 1'b0;
      xoff_q      <= 1'b0;
    end else begin
      thr_empty_q <= thr_empty_i;
      thre_arm_q  <= thre_arm_d_o;
      xoff_q      <= xoff_d_o;
    end
  end
endmodule

// File: rtl/uart_intid_prio.sv
module uart_intid_prio
  import uart_intid_pkg::*;
(
  input  logic [NUM_SRC-1:0] act_i,
  output logic [ID_W-1:0]    id_o,
  output logic               none_o
);
  logic [NUM_SRC:0]   blk;
  logic [NUM_SRC-1:0] sel;

  assign blk[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
    assign sel[g]   = act_i[g] & ~blk[g];
    assign blk[g+1] = blk[g] | act_i[g];
  end

  always_comb begin
    id_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel[i]) id_o = id_o | src_code(i);
    end
  end

  assign none_o = ~blk[NUM_SRC];
endmodule

// File: rtl/uart_intid.sv
module uart_intid
  import uart_intid_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               lsr_err_i,
  input  logic               rx_tmo_i,
  input  logic               rx_rdy_i,
  input  logic               thr_empty_i,
  input  logic               modem_chg_i,
  input  logic               flow_chg_i,
  input  logic               xoff_det_i,
  input  logic               xon_det_i,
  input  logic               enh_en_i,
  input  logic               fifo_en_i,
  input  logic               rd_stat_i,
  output logic [7:0]         stat_o,
  output logic               irq_o
);
  logic [7:0]         stat_q, stat_d;
  logic               irq_q, irq_d;
  logic               thre_arm_d, xoff_d;
  logic               thre_shown;
  logic [NUM_SRC-1:0] raw, act;
  logic [ID_W-1:0]    id;
  logic               none;

  assign thre_shown = rd_stat_i & (stat_q[3:0] == 4'b0010);

  uart_intid_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .thr_empty_i  (thr_empty_i),
    .thre_clr_i   (thre_shown),
    .xoff_set_i   (xoff_det_i & enh_en_i),
    .xon_i        (xon_det_i),
    .thre_arm_d_o (thre_arm_d),
    .xoff_d_o     (xoff_d)
  );

  always_comb begin
    raw           = '0;
    raw[SRC_LSR]  = lsr_err_i;
    raw[SRC_TMO]  = rx_tmo_i;
    raw[SRC_RDY]  = rx_rdy_i;
    raw[SRC_THRE] = thre_arm_d;
    raw[SRC_MSR]  = modem_chg_i;
    raw[SRC_XOFF] = xoff_d & enh_en_i;
    raw[SRC_FLOW] = flow_chg_i & enh_en_i;
    act           = raw & src_en_i;
  end

  uart_intid_prio u_prio (
    .act_i  (act),
    .id_o   (id),
    .none_o (none)
  );

  always_comb begin
    stat_d = {{2{fifo_en_i}}, id, none};
    irq_d  = ~none;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 8'h01;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [6:0] src_en_i,
  input logic       lsr_err_i,
  input logic       rx_tmo_i,
  input logic       enh_en_i,
  input logic       fifo_en_i,
  input logic [7:0] stat_o,
  input logic       irq_o
);
  a_r2_irq_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ~stat_o[0]);

  a_r5_idle_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_i == 7'd0) |=> stat_o[5:0] == 6'b000001);

  a_r3_lsr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_err_i && src_en_i[0]) |=> stat_o[5:0] == 6'b000110);

  a_r4_timeout_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_tmo_i && src_en_i[1] && !(lsr_err_i && src_en_i[0])) |=> stat_o[5:0] == 6'b001100);

  a_r6_enh_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_i |=> stat_o[5:4] == 2'b00);

  a_r8_fifo_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stat_o[7:6] == {2{$past(fifo_en_i)}});
endmodule

bind uart_intid uart_intid_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_en_i  (src_en_i),
  .lsr_err_i (lsr_err_i),
  .rx_tmo_i  (rx_tmo_i),
  .enh_en_i  (enh_en_i),
  .fifo_en_i (fifo_en_i),
  .stat_o    (stat_o),
  .irq_o     (irq_o)
);

// File: tb/uart_intid_bench.sv
module uart_intid_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [6:0] src_en_i;
  logic       lsr_err_i, rx_tmo_i, rx_rdy_i, thr_empty_i, modem_chg_i, flow_chg_i;
  logic       xoff_det_i, xon_det_i, enh_en_i, fifo_en_i, rd_stat_i;
  logic [7:0] stat_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #5 clk_i = ~clk_i;

  uart_intid u_uart_intid (.*);

  // {en[6:0], lsr, tmo, rdy, msr, flow, enh, fifo, expected[7:0]}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {7'h7F, 5'b00000, 1'b1, 1'b0, 8'h01},   // R2 idle
    {7'h7F, 5'b11111, 1'b1, 1'b1, 8'hC6},   // R3 line status top, R8
    {7'h7F, 5'b01110, 1'b1, 1'b0, 8'h0C},   // R4 timeout over ready
    {7'h7F, 5'b00110, 1'b1, 1'b0, 8'h04},   // R3 ready over modem
    {7'h7F, 5'b00011, 1'b1, 1'b0, 8'h00},   // R3 modem over handshake
    {7'h7F, 5'b00001, 1'b1, 1'b0, 8'h20},   // R3 handshake
    {7'h7F, 5'b00001, 1'b0, 1'b0, 8'h01},   // R6 masked
    {7'h7E, 5'b10100, 1'b1, 1'b0, 8'h04},   // R5 line status disabled
    {7'h00, 5'b11111, 1'b1, 1'b1, 8'hC1},   // R5 all disabled
    {7'h7D, 5'b01100, 1'b1, 1'b0, 8'h04},   // R5 timeout disabled
    {7'h7F, 5'b01000, 1'b1, 1'b1, 8'hCC},   // R8 fifo bits, R4
    {7'h6F, 5'b00011, 1'b1, 1'b0, 8'h20}    // R5 modem disabled
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (stat_o !== exp || irq_o !== ~exp[0]) begin
      n_err++;
      $display("FAIL %s: stat=%02h irq=%0b expected stat=%02h irq=%0b",
               req, stat_o, irq_o, exp, ~exp[0]);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle_inputs();
    src_en_i = 7'h7F; lsr_err_i = 0; rx_tmo_i = 0; rx_rdy_i = 0;
    thr_empty_i = 0; modem_chg_i = 0; flow_chg_i = 0; xoff_det_i = 0;
    xon_det_i = 0; enh_en_i = 1; fifo_en_i = 0; rd_stat_i = 0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 5000) begin
      n_err++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_ni = 1'b0;
    #23;
    check("R1 reset", 8'h01);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    check("R1 after release", 8'h01);

    // Vector table (R10: one-cycle latency)
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      src_en_i    = v[21:15];
      lsr_err_i   = v[14];
      rx_tmo_i    = v[13];
      rx_rdy_i    = v[12];
      modem_chg_i = v[11];
      flow_chg_i  = v[10];
      enh_en_i    = v[9];
      fifo_en_i   = v[8];
      step();
      check($sformatf("R3/R10 vector %0d", i), v[7:0]);
    end
    idle_inputs();
    step();
    check("R2 back to idle", 8'h01);

    // Transmit empty: R9
    thr_empty_i = 1;
    step();
    check("R9 armed by rising edge", 8'h02);
    rd_stat_i = 1;
    step();
    rd_stat_i = 0;
    check("R9 cleared by read", 8'h01);
    step();
    check("R9 level alone does not re-arm", 8'h01);
    thr_empty_i = 0;
    step();
    thr_empty_i = 1;
    step();
    check("R9 re-armed by new edge", 8'h02);
    lsr_err_i = 1;
    step();
    check("R3 line status hides transmit empty", 8'h06);
    rd_stat_i = 1;
    step();
    rd_stat_i = 0;
    lsr_err_i = 0;
    step();
    check("R9 read of other code keeps it armed", 8'h02);
    thr_empty_i = 0;
    step();
    check("R9 idle after empty drops", 8'h01);

    // Stop-character flag: R7, R6
    xoff_det_i = 1;
    step();
    xoff_det_i = 0;
    check("R7 stop flag set", 8'h10);
    rd_stat_i = 1;
    step();
    step();
    rd_stat_i = 0;
    check("R7 stop flag survives reads", 8'h10);
    xon_det_i = 1;
    step();
    xon_det_i = 0;
    check("R7 resume clears flag", 8'h01);
    xoff_det_i = 1; xon_det_i = 1;
    step();
    xoff_det_i = 0; xon_det_i = 0;
    check("R7 resume wins same cycle", 8'h01);
    enh_en_i = 0;
    xoff_det_i = 1;
    step();
    xoff_det_i = 0;
    check("R6 stop pulse masked", 8'h01);
    enh_en_i = 1;
    step();
    check("R6 stop pulse not recorded", 8'h01);
    src_en_i = 7'h5F;
    xoff_det_i = 1;
    step();
    xoff_det_i = 0;
    check("R5 stop source disabled", 8'h01);
    src_en_i = 7'h7F;
    step();
    check("R5 stop flag held while disabled", 8'h10);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule